// File: doc/BRIEF.md
# Queued SPI Master Controller

This block is an SPI master that works through a short list of byte transfers without processor help between bytes. Software fills a per-slot transmit byte and a per-slot command byte, programs a start slot and an end slot, and sets an enable bit. The engine then visits each slot from the start slot to the end slot inclusive, wrapping modulo the slot count. For each slot it shifts one byte out MSB first in SPI mode 3, captures the byte returned on the input line, and writes it into a receive memory.

The command byte of each slot decides whether chip select stays asserted into the next slot. When the last slot completes, a sticky done flag is raised and, if enabled, an interrupt request. A lock bit, or the continue control bit, can keep chip select asserted after a run so that one device transaction can span several runs. The SCK half period equals the divisor register in system clock cycles, with a floor of 8.

Access is through a simple 32-bit register bus with a byte address. A write is taken on any clock edge where `bus_wr` is high. A read is requested by `bus_rd` and its data appears on `bus_rdata` in the following cycle. Transmit and command memories are write-only from the bus and read back as zero.

Top module: `qspi_master`

## Requirements
- R1: After reset, `spi_cs_n` is 1, `spi_sck` is 1, `irq` is 0 and the status word (0x020) reads 0.
- R2: A run sends the transmit byte of each slot from the new-queue pointer (0x010) to the end-queue pointer (0x014) inclusive, in slot order. Slot n's byte is written at word 2n of the transmit area (byte address 0x040 + 8n). Bytes go out MSB first in mode 3: SCK idles high, MOSI changes on the falling edge and is sampled on the rising edge.
- R3: The byte received during slot n is read at word 2n+1 of the receive area (byte address 0x0C4 + 8n), in bits 7:0, with bits 31:8 zero.
- R4: If bit 7 of a slot's command byte (command area 0x140 + 4n) is 1, chip select stays low into the next slot. If it is 0, chip select goes high after that slot.
- R5: When the end slot finishes, status bit 0 is set. `irq` follows status bit 0 ANDed with control bit 5 (control at 0x018).
- R6: Writing status with bit 0 equal to 0 clears the done flag, which in turn drops `irq`.
- R7: The SCK half period is max(divisor, 8) clock cycles. The divisor is held in bits 7:0 at 0x000.
- R8: A run starts when control bit 6 is 1 and the engine is idle. After a run ends, no further run starts until bit 6 has been written 0 and then 1 again.
- R9: The lock bit (0x180, bit 0) can be read back. Chip select stays low after the last slot only when that slot's command bit 7 is 1 and either the lock bit or control bit 7 is 1. While the engine is idle, a held chip select is released once both of those bits are 0.
- R10: The divisor registers (0x000, 0x004), the pointer registers (4 bits each) and control bits 7:5 read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 9 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read request; data follows one cycle later |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data |
| spi_sck | output | 1 | Serial clock, idles high |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| irq | output | 1 | Queue-finished interrupt request |

## Verification
Some rules are checked by assertions on every cycle. The engine never shifts while chip select is high. SCK stays high whenever no byte is in flight. Divider ticks never come on back-to-back cycles. Done rises only in the cycle after the end slot finishes, and a run leaves idle only with enable set. A status write of 0 clears done. Other behaviour shows only in the bench's scenarios. These include the exact byte order on MOSI, the receive-memory placement and the measured half period for small and large divisors. They also include the number of chip-select releases under different command bits, chip select held by the lock, and the absence of a second run while enable stays set.

// File: rtl/qspi_pkg.sv
package qspi_pkg;
  localparam int ADDR_W = 9;
  localparam int WORD_W = ADDR_W - 2;
  typedef logic [WORD_W-1:0] word_t;

  localparam word_t W_DIVLO = 7'd0;
  localparam word_t W_DIVHI = 7'd1;
  localparam word_t W_NEWQ  = 7'd4;
  localparam word_t W_ENDQ  = 7'd5;
  localparam word_t W_CTRL  = 7'd6;
  localparam word_t W_STAT  = 7'd8;
  localparam word_t W_TX    = 7'd16;
  localparam word_t W_RX    = 7'd48;
  localparam word_t W_CMD   = 7'd80;
  localparam word_t W_LOCK  = 7'd96;

  typedef enum logic [2:0] {ST_IDLE, ST_LOAD, ST_KICK, ST_RUN, ST_FIN} eng_state_t;
endpackage

// File: rtl/qspi_ram.sv
module qspi_ram #(
  parameter int AW = 5,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 2 ** AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/qspi_clkdiv.sv
module qspi_clkdiv #(
  parameter int DIV_W   = 8,
  parameter int MIN_DIV = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  localparam logic [DIV_W-1:0] MIN_V = DIV_W'(MIN_DIV);
  logic [DIV_W-1:0] eff, cnt;

  assign eff = (div < MIN_V) ? MIN_V : div;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == eff - DIV_W'(1)) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + DIV_W'(1);
      tick <= 1'b0;
    end
  end

  // R7: with a floor of 8 ticks can never be adjacent
  a_r7_tick_spacing: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);
endmodule

// File: rtl/qspi_shifter.sv
module qspi_shifter #(
  parameter int BITS = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [BITS-1:0] din,
  input  logic            tick,
  input  logic            miso,
  output logic            sck,
  output logic            mosi,
  output logic            busy,
  output logic            done,
  output logic [BITS-1:0] dout
);
  localparam int STEPS = 2 * BITS;
  localparam int CW    = $clog2(STEPS + 1);
  logic [CW-1:0]   step;
  logic [BITS-1:0] sreg;

  assign dout = sreg;

  always_ff @(posedge clk) begin
    done <= 1'b0;
    if (rst) begin
      step <= '0;
      sreg <= '0;
      sck  <= 1'b1;
      mosi <= 1'b1;
      busy <= 1'b0;
    end else if (start && !busy) begin
      sreg <= din;
      step <= '0;
      busy <= 1'b1;
    end else if (busy && tick) begin
      if (step == CW'(STEPS)) begin
        busy <= 1'b0;
        done <= 1'b1;
      end else if (!step[0]) begin
        sck  <= 1'b0;
        mosi <= sreg[BITS-1];
      end else begin
        sck  <= 1'b1;
        sreg <= {sreg[BITS-2:0], miso};
      end
      step <= step + CW'(1);
    end
  end

  // R2: SCK rests high between bytes (mode 3)
  a_r2_sck_idle_high: assert property (@(posedge clk) disable iff (rst)
    !busy |-> sck);
endmodule

// File: rtl/qspi_master.sv
module qspi_master
  import qspi_pkg::*;
#(
  parameter int SLOTS   = 16,
  parameter int DIV_W   = 8,
  parameter int MIN_DIV = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [8:0]  bus_addr,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        spi_sck,
  output logic        spi_cs_n,
  output logic        spi_mosi,
  input  logic        spi_miso,
  output logic        irq
);
  localparam int SW = $clog2(SLOTS);
  localparam int RW = SW + 1;

  word_t word, off_tx, off_rx, off_cmd;
  logic  hit_tx, hit_rx, hit_cmd;
  assign word    = bus_addr[ADDR_W-1:2];
  assign hit_tx  = (word >= W_TX)  && (word < W_RX);
  assign hit_rx  = (word >= W_RX)  && (word < W_CMD);
  assign hit_cmd = (word >= W_CMD) && (word < W_LOCK);
  assign off_tx  = word - W_TX;
  assign off_rx  = word - W_RX;
  assign off_cmd = word - W_CMD;

  logic [DIV_W-1:0] div_lo;
  logic [7:0]       div_hi;
  logic [SW-1:0]    newq, endq, slot;
  logic             cont, spe, ie, done_q, lock;
  eng_state_t       state;
  logic             cs_on, cmd_hold;

  logic [7:0] tx_q, cmd_q, rx_q, sh_dout;
  logic       sh_start, sh_busy, sh_done, tick, end_evt, rx_we;

  assign sh_start = (state == ST_KICK);
  assign end_evt  = (state == ST_RUN) && sh_done && (slot == endq);
  assign rx_we    = (state == ST_RUN) && sh_done;

  qspi_ram #(.AW(RW), .DW(8)) u_txram (
    .clk(clk), .we(bus_wr && hit_tx), .waddr(off_tx[RW-1:0]),
    .wdata(bus_wdata[7:0]), .raddr({slot, 1'b0}), .rdata(tx_q));

  qspi_ram #(.AW(SW), .DW(8)) u_cmdram (
    .clk(clk), .we(bus_wr && hit_cmd), .waddr(off_cmd[SW-1:0]),
    .wdata(bus_wdata[7:0]), .raddr(slot), .rdata(cmd_q));

  qspi_ram #(.AW(RW), .DW(8)) u_rxram (
    .clk(clk), .we(rx_we), .waddr({slot, 1'b1}),
    .wdata(sh_dout), .raddr(off_rx[RW-1:0]), .rdata(rx_q));

  qspi_clkdiv #(.DIV_W(DIV_W), .MIN_DIV(MIN_DIV)) u_div (
    .clk(clk), .rst(rst), .run(sh_busy), .div(div_lo), .tick(tick));

  qspi_shifter #(.BITS(8)) u_shift (
    .clk(clk), .rst(rst), .start(sh_start), .din(tx_q), .tick(tick),
    .miso(spi_miso), .sck(spi_sck), .mosi(spi_mosi), .busy(sh_busy),
    .done(sh_done), .dout(sh_dout));

  // register file
  always_ff @(posedge clk) begin
    if (rst) begin
      div_lo <= '0;
      div_hi <= '0;
      newq   <= '0;
      endq   <= '0;
      cont   <= 1'b0;
      spe    <= 1'b0;
      ie     <= 1'b0;
      lock   <= 1'b0;
      done_q <= 1'b0;
      irq    <= 1'b0;
    end else begin
      if (bus_wr) begin
        case (word)
          W_DIVLO: div_lo <= bus_wdata[DIV_W-1:0];
          W_DIVHI: div_hi <= bus_wdata[7:0];
          W_NEWQ:  newq   <= bus_wdata[SW-1:0];
          W_ENDQ:  endq   <= bus_wdata[SW-1:0];
          W_CTRL:  {cont, spe, ie} <= bus_wdata[7:5];
          W_STAT:  if (!bus_wdata[0]) done_q <= 1'b0;
          W_LOCK:  lock   <= bus_wdata[0];
          default: ;
        endcase
      end
      if (end_evt) done_q <= 1'b1;
      irq <= done_q && ie;
    end
  end

  // queue engine
  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      slot     <= '0;
      cs_on    <= 1'b0;
      cmd_hold <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (!(lock || cont)) cs_on <= 1'b0;
          if (spe) begin
            slot  <= newq;
            state <= ST_LOAD;
          end
        end
        ST_LOAD: state <= ST_KICK;
        ST_KICK: begin
          cs_on    <= 1'b1;
          cmd_hold <= cmd_q[7];
          state    <= ST_RUN;
        end
        ST_RUN: begin
          if (sh_done) begin
            if (slot == endq) begin
              cs_on <= cmd_hold && (cont || lock);
              state <= ST_FIN;
            end else begin
              cs_on <= cmd_hold;
              slot  <= slot + SW'(1);
              state <= ST_LOAD;
            end
          end
        end
        ST_FIN:  if (!spe) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign spi_cs_n = !cs_on;

  // read path: one cycle latency
  logic        rd_rx;
  logic [31:0] rd_val;
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_rx  <= 1'b0;
      rd_val <= '0;
    end else begin
      rd_rx  <= bus_rd && hit_rx;
      rd_val <= '0;
      if (bus_rd) begin
        case (word)
          W_DIVLO: rd_val <= 32'(div_lo);
          W_DIVHI: rd_val <= 32'(div_hi);
          W_NEWQ:  rd_val <= 32'(newq);
          W_ENDQ:  rd_val <= 32'(endq);
          W_CTRL:  rd_val <= {24'd0, cont, spe, ie, 5'd0};
          W_STAT:  rd_val <= {31'd0, done_q};
          W_LOCK:  rd_val <= {31'd0, lock};
          default: rd_val <= '0;
        endcase
      end
    end
  end
  assign bus_rdata = rd_rx ? {24'd0, rx_q} : rd_val;

  logic unused_bits;
  assign unused_bits = ^{bus_addr[1:0], bus_wdata[31:8], off_tx, off_rx, off_cmd};

  // R4: bits only shift while chip select is asserted
  a_r4_cs_during_shift: assert property (@(posedge clk) disable iff (rst)
    sh_busy |-> !spi_cs_n);
  // R5: done rises only right after the end slot finishes
  a_r5_done_at_end: assert property (@(posedge clk) disable iff (rst)
    $rose(done_q) |-> $past((state == ST_RUN) && sh_done && (slot == endq)));
  // R6: a zero written to status bit 0 clears done
  a_r6_status_clear: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && (word == W_STAT) && !bus_wdata[0] && !end_evt) |=> !done_q);
  // R8: a run leaves idle only with enable set
  a_r8_start_needs_enable: assert property (@(posedge clk) disable iff (rst)
    $fell(state == ST_IDLE) |-> $past(spe));
endmodule

// File: tb/qspi_master_test.sv
module qspi_master_test;
  localparam logic [8:0] A_DIVLO = 9'h000, A_DIVHI = 9'h004, A_NEWQ = 9'h010,
                         A_ENDQ = 9'h014, A_CTRL = 9'h018, A_STAT = 9'h020,
                         A_TX = 9'h040, A_RX = 9'h0C0, A_CMD = 9'h140, A_LOCK = 9'h180;

  logic clk = 1'b0, rst = 1'b1;
  logic [8:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        spi_sck, spi_cs_n, spi_mosi, irq;
  logic        spi_miso = 1'b1;

  int checks = 0, fails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  qspi_master uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_sck(spi_sck),
    .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso), .irq(irq));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] resp_of(input int i);
    return 8'(8'h3C ^ (i * 17));
  endfunction

  // slave model plus scoreboard monitor
  logic [7:0] exp_q[$];
  logic [7:0] exp_rx[16];
  logic [7:0] got = '0;
  logic [7:0] resp;
  int bitcnt = 0, sidx = 0, nidx = 0, cs_rises = 0;
  initial resp = resp_of(0);

  always @(negedge spi_sck) if (spi_cs_n === 1'b0) spi_miso = resp[7-bitcnt];

  always @(posedge spi_sck) if (spi_cs_n === 1'b0) begin
    got = {got[6:0], spi_mosi};
    bitcnt++;
    if (bitcnt == 8) begin
      bitcnt = 0;
      if (exp_q.size() == 0) chk(0, "R2 unexpected byte", 32'(got), 32'hFFFF_FFFF);
      else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        chk(got == e, "R2 mosi byte", 32'(got), 32'(e));
      end
      sidx++;
      resp = resp_of(sidx);
    end
  end

  always @(posedge spi_cs_n) if (!rst) cs_rises++;

  task automatic bwrite(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic bread(input logic [8:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  // driver: program one slot and push what the scoreboard should see
  task automatic load_slot(input int s, input logic [7:0] tx, input logic [7:0] cmd);
    bwrite(9'(A_TX + 9'(8 * s)), {24'd0, tx});
    bwrite(9'(A_CMD + 9'(4 * s)), {24'd0, cmd});
    exp_q.push_back(tx);
    exp_rx[s] = resp_of(nidx);
    nidx++;
  endtask

  task automatic wait_done();
    logic [31:0] v;
    for (int i = 0; i < 6000; i++) begin
      bread(A_STAT, v);
      if (v[0]) break;
    end
  endtask

  task automatic measure(output int n);
    n = 0;
    @(negedge spi_sck);
    do begin @(posedge clk); #1; n++; end while (spi_sck == 1'b0);
  endtask

  task automatic chk_rx(input int s, input string req);
    logic [31:0] v;
    bread(9'(A_RX + 9'(8 * s + 4)), v);
    chk(v == {24'd0, exp_rx[s]}, req, v, {24'd0, exp_rx[s]});
  endtask

  initial begin
    logic [31:0] v;
    int hp, c0, s0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(spi_cs_n == 1'b1, "R1 cs_n", 32'(spi_cs_n), 1);
    chk(spi_sck == 1'b1, "R1 sck", 32'(spi_sck), 1);
    chk(irq == 1'b0, "R1 irq", 32'(irq), 0);
    bread(A_STAT, v); chk(v == 0, "R1 status", v, 0);

    // R10 readback
    bwrite(A_DIVLO, 32'd3);   bread(A_DIVLO, v); chk(v == 3, "R10 divisor", v, 3);
    bwrite(A_DIVHI, 32'h23);  bread(A_DIVHI, v); chk(v == 32'h23, "R10 word/mode", v, 32'h23);
    bwrite(A_NEWQ, 32'd0);    bwrite(A_ENDQ, 32'd2);
    bread(A_ENDQ, v); chk(v == 2, "R10 end pointer", v, 2);

    // run A: slots 0..2, CS held across slots, released at end
    load_slot(0, 8'hA1, 8'h8E);
    load_slot(1, 8'h5B, 8'h8E);
    load_slot(2, 8'hC3, 8'h0E);
    c0 = cs_rises;
    bwrite(A_CTRL, 32'h60);
    bread(A_CTRL, v); chk(v == 32'h60, "R10 control", v, 32'h60);
    measure(hp); chk(hp == 8, "R7 half period floor", 32'(hp), 8);
    wait_done();
    bread(A_STAT, v); chk(v == 1, "R5 done set", v, 1);
    chk(irq == 1'b1, "R5 irq enabled", 32'(irq), 1);
    chk(cs_rises - c0 == 1, "R4 cs held between slots", 32'(cs_rises - c0), 1);
    chk(exp_q.size() == 0, "R2 all slots sent", 32'(exp_q.size()), 0);
    chk(spi_sck == 1'b1, "R2 sck idle high", 32'(spi_sck), 1);
    chk_rx(0, "R3 rx slot0"); chk_rx(1, "R3 rx slot1"); chk_rx(2, "R3 rx slot2");

    // R6 clear, R8 no restart while enable stays set
    bwrite(A_STAT, 32'd0);
    bread(A_STAT, v); chk(v == 0, "R6 status cleared", v, 0);
    chk(irq == 1'b0, "R6 irq dropped", 32'(irq), 0);
    s0 = sidx;
    repeat (300) @(negedge clk);
    bread(A_STAT, v); chk(v == 0, "R8 no rerun status", v, 0);
    chk(sidx == s0, "R8 no rerun bytes", 32'(sidx), 32'(s0));

    // run B: slots 5..7, release after 5, hold after 6, bit7 on last with no lock
    bwrite(A_CTRL, 32'h00);
    bwrite(A_DIVLO, 32'd12);
    bwrite(A_NEWQ, 32'd5); bwrite(A_ENDQ, 32'd7);
    load_slot(5, 8'h0F, 8'h0E);
    load_slot(6, 8'hF0, 8'h8E);
    load_slot(7, 8'h96, 8'h8E);
    c0 = cs_rises;
    bwrite(A_CTRL, 32'h40);
    measure(hp); chk(hp == 12, "R7 half period divisor", 32'(hp), 12);
    wait_done();
    bread(A_STAT, v); chk(v == 1, "R5 done set run B", v, 1);
    chk(irq == 1'b0, "R5 irq masked", 32'(irq), 0);
    chk(cs_rises - c0 == 2, "R4 R9 cs releases", 32'(cs_rises - c0), 2);
    chk(spi_cs_n == 1'b1, "R9 released without lock", 32'(spi_cs_n), 1);
    chk_rx(5, "R3 rx slot5"); chk_rx(6, "R3 rx slot6"); chk_rx(7, "R3 rx slot7");

    // run C: lock holds CS after the run
    bwrite(A_STAT, 32'd0);
    bwrite(A_CTRL, 32'h00);
    bwrite(A_LOCK, 32'd1);
    bread(A_LOCK, v); chk(v == 1, "R9 lock readback", v, 1);
    bwrite(A_NEWQ, 32'd9); bwrite(A_ENDQ, 32'd9);
    load_slot(9, 8'h3A, 8'h8E);
    bwrite(A_CTRL, 32'h40);
    wait_done();
    chk(spi_cs_n == 1'b0, "R9 cs held by lock", 32'(spi_cs_n), 0);
    chk_rx(9, "R3 rx slot9");
    bwrite(A_CTRL, 32'h00);
    repeat (4) @(negedge clk);
    chk(spi_cs_n == 1'b0, "R9 cs held while locked idle", 32'(spi_cs_n), 0);
    bwrite(A_LOCK, 32'd0);
    repeat (4) @(negedge clk);
    chk(spi_cs_n == 1'b1, "R9 cs released on unlock", 32'(spi_cs_n), 1);

    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule